// File: doc/BRIEF.md
# SPI Master Burst Shift Engine

This block is the byte-serial core of an SPI master. It sits between a transmit queue and a receive queue. One start pulse runs a whole burst. The burst length gives the total number of bytes clocked on the bus. A separate transmit length gives how many of those bytes are taken from the transmit queue. Once that many have been sent, the engine keeps clocking and shifts out zero bytes until the burst ends.

Each received byte is pushed into the receive queue unless the discard option is set. The discard option is meant for transmit-only transfers. Serial timing comes from a clock-enable tick supplied by an external divider, and each tick produces one SCLK edge. Both clock polarities, both clock phases and either bit order are supported. When the burst ends, the engine sets a completion flag in a small interrupt status word. Writing a one to a status bit clears it, and the interrupt line is raised for any status bit whose enable bit is set.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, sclk is 0, mosi is 0, busy is 0, the status word is 0, irq is 0, and neither tx_pop nor rx_push is asserted.
- R2: While no burst runs, sclk rests at the level given by cfg_cpol. The new level appears within three clock cycles of a change to cfg_cpol.
- R3: A start pulse given while idle raises busy on the next cycle. The engine then clocks exactly 16 SCLK edges per byte for burst_len bytes and drops busy. One cycle after busy falls, status bit 16 (the completion flag) reads 1.
- R4: With cfg_cpha = 0, each mosi bit is valid before the leading SCLK edge and changes only on trailing edges. miso is sampled on leading edges. With cfg_lsb_first = 0, bit 7 goes first.
- R5: With cfg_cpha = 1, mosi changes on leading SCLK edges and miso is sampled on trailing edges.
- R6: With cfg_lsb_first = 1, bit 0 of every byte is sent and received first, in both directions.
- R7: Only the first tx_len bytes of a burst pop the transmit queue. Each byte after them is sent as 0x00 without a pop.
- R8: With cfg_discard_rx = 1 at start, no received byte is pushed (rx_push stays 0). Otherwise each of the burst_len received bytes is pushed once, in order.
- R9: A start pulse given while busy is 1 is ignored. It neither lengthens the running burst nor launches a new one.
- R10: Writing 1 to bit n of int_clr clears status bit n, and zeros have no effect. irq is the OR over all bits of status AND int_en, and it appears one cycle after the status word.
- R11: A burst with burst_len = 0 produces no SCLK edge and still completes, setting status bit 16.
- R12: When a byte is due from the transmit queue and tx_valid is 0, the engine waits with no SCLK edge and busy held at 1 until data arrives.
- R13: Configuration and both lengths are sampled at the start pulse. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_tick | input | 1 | Clock-enable from the baud divider, one SCLK edge per tick |
| cfg_cpol | input | 1 | Idle SCLK level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: bit 0 shifted first |
| cfg_discard_rx | input | 1 | 1: received bytes are not pushed |
| burst_len | input | CNT_W | Total bytes clocked in one burst |
| tx_len | input | CNT_W | Bytes of the burst taken from the transmit queue |
| start | input | 1 | Start pulse |
| int_en | input | STS_W | Interrupt enable mask |
| int_clr | input | STS_W | Write-one-to-clear strobe for the status word |
| int_sts | output | STS_W | Interrupt status, bit DONE_BIT is the completion flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Burst in progress |
| tx_valid | input | 1 | Transmit queue holds a byte |
| tx_data | input | 8 | Head of the transmit queue |
| tx_pop | output | 1 | Consume the head of the transmit queue |
| rx_push | output | 1 | Write rx_data into the receive queue |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench puts a bit-accurate slave model on the bus. The model shifts a distinct byte per position back on miso and captures mosi on the edge the chosen phase calls for. This is repeated under all four polarity and phase pairs and both bit orders, so a sample taken on the wrong edge or a reversed bit order shows as a corrupted byte. Bursts whose transmit length is shorter than the burst length separate real queue data from zero filler and count the pops. Discard mode separates the shifted bus traffic from the receive pushes. An empty transmit queue at start, a second start mid-burst, a zero-length burst, and length or configuration changes during a burst each check that no edge is added or lost.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FETCH,
    SEQ_SHIFT
  } seq_state_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
    logic discard_rx;
  } xfer_cfg_t;

endpackage

// File: rtl/spi_bit_shifter.sv
// Shifts one byte: 2*BYTE_W SCLK edges, one per tick.
module spi_bit_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam int EDGE_W = IDX_W + 1;
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * BYTE_W - 1);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(BYTE_W - 1);

  logic              active_q;
  logic [EDGE_W-1:0] edge_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] rx_out_q;
  logic              sclk_q;
  logic              mosi_q;
  logic              done_q;

  logic [IDX_W-1:0]  bit_k;
  logic [IDX_W-1:0]  rx_pos;
  logic              leading;
  logic              sample_now;
  logic [BYTE_W-1:0] rx_next;

  // bit k in shift order
  function automatic logic pick(input logic [BYTE_W-1:0] b,
                                input logic [IDX_W-1:0] k,
                                input logic lsb);
    return lsb ? b[k] : b[LAST_BIT - k];
  endfunction

  assign bit_k      = edge_q[EDGE_W-1:1];
  assign leading    = ~edge_q[0];
  assign sample_now = active_q && tick && (leading ^ cpha);
  assign rx_pos     = lsb_first ? bit_k : LAST_BIT - bit_k;

  always_comb begin
    rx_next = rx_q;
    if (sample_now) rx_next[rx_pos] = miso;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      edge_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      rx_out_q <= '0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        sclk_q <= cpol;
        if (load) begin
          active_q <= 1'b1;
          edge_q   <= '0;
          tx_q     <= load_byte;
          rx_q     <= '0;
          if (!cpha) mosi_q <= pick(load_byte, '0, lsb_first);
        end
      end else if (tick) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + EDGE_W'(1);
        rx_q   <= rx_next;
        if (leading && cpha)
          mosi_q <= pick(tx_q, bit_k, lsb_first);
        if (!leading && !cpha && (bit_k != LAST_BIT))
          mosi_q <= pick(tx_q, bit_k + IDX_W'(1), lsb_first);
        if (edge_q == LAST_EDGE) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          rx_out_q <= rx_next;
        end
      end
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = mosi_q;
  assign byte_done = done_q;
  assign rx_byte   = rx_out_q;

endmodule

// File: rtl/spi_byte_sequencer.sv
// Byte-level control: burst/transmit counters, queue handshakes.
module spi_byte_sequencer
  import spi_burst_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  xfer_cfg_t         cfg_in,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  output xfer_cfg_t         cfg,
  output logic              busy,
  output logic              done
);
  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  burst_q;
  logic [CNT_W-1:0]  txlen_q;
  xfer_cfg_t         cfg_q;
  logic              busy_q;
  logic              done_q;
  logic              push_q;
  logic [BYTE_W-1:0] rxd_q;

  logic at_end;
  logic need_tx;
  logic in_fetch;

  assign at_end    = (cnt_q == burst_q);
  assign need_tx   = (cnt_q < txlen_q);
  assign in_fetch  = (state_q == SEQ_FETCH) && !at_end;
  assign tx_pop    = in_fetch && need_tx && tx_valid;
  assign load      = in_fetch && (!need_tx || tx_valid);
  assign load_byte = need_tx ? tx_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      burst_q <= '0;
      txlen_q <= '0;
      cfg_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      push_q  <= 1'b0;
      rxd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      push_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          cfg_q <= cfg_in;
          if (start) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            burst_q <= burst_len;
            txlen_q <= tx_len;
            state_q <= SEQ_FETCH;
          end
        end
        SEQ_FETCH: begin
          if (at_end) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= SEQ_IDLE;
          end else if (load) begin
            state_q <= SEQ_SHIFT;
          end
        end
        SEQ_SHIFT: begin
          if (byte_done) begin
            cnt_q   <= cnt_q + CNT_W'(1);
            push_q  <= !cfg_q.discard_rx;
            rxd_q   <= rx_byte;
            state_q <= SEQ_FETCH;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign rx_push = push_q;
  assign rx_data = rxd_q;
  assign cfg     = cfg_q;
  assign busy    = busy_q;
  assign done    = done_q;

endmodule

// File: rtl/spi_irq_status.sv
// Write-one-to-clear status word and masked interrupt.
module spi_irq_status #(
  parameter int STS_W    = 32,
  parameter int DONE_BIT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_done,
  input  logic [STS_W-1:0] clr,
  input  logic [STS_W-1:0] en,
  output logic [STS_W-1:0] sts,
  output logic             irq
);
  logic [STS_W-1:0] sts_q;
  logic             irq_q;

  for (genvar i = 0; i < STS_W; i++) begin : g_bit
    if (i == DONE_BIT) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) sts_q[i] <= 1'b0;
        else     sts_q[i] <= set_done | (sts_q[i] & ~clr[i]);
      end
    end else begin : g_unused
      assign sts_q[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(sts_q & en);
  end

  assign sts = sts_q;
  assign irq = irq_q;

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int STS_W    = 32,
  parameter int DONE_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_tick,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_discard_rx,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              start,
  input  logic [STS_W-1:0]  int_en,
  input  logic [STS_W-1:0]  int_clr,
  output logic [STS_W-1:0]  int_sts,
  output logic              irq,
  output logic              busy,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  xfer_cfg_t         cfg_live;
  xfer_cfg_t         cfg_run;
  logic              shf_load;
  logic [BYTE_W-1:0] shf_byte;
  logic              shf_done;
  logic [BYTE_W-1:0] shf_rx;
  logic              seq_done;

  assign cfg_live = '{cpol: cfg_cpol, cpha: cfg_cpha,
                      lsb_first: cfg_lsb_first, discard_rx: cfg_discard_rx};

  spi_byte_sequencer #(
    .CNT_W (CNT_W),
    .BYTE_W(BYTE_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cfg_in   (cfg_live),
    .burst_len(burst_len),
    .tx_len   (tx_len),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_pop   (tx_pop),
    .byte_done(shf_done),
    .rx_byte  (shf_rx),
    .load     (shf_load),
    .load_byte(shf_byte),
    .rx_push  (rx_push),
    .rx_data  (rx_data),
    .cfg      (cfg_run),
    .busy     (busy),
    .done     (seq_done)
  );

  spi_bit_shifter #(
    .BYTE_W(BYTE_W)
  ) u_shf (
    .clk      (clk),
    .rst      (rst),
    .tick     (sclk_tick),
    .cpol     (cfg_run.cpol),
    .cpha     (cfg_run.cpha),
    .lsb_first(cfg_run.lsb_first),
    .load     (shf_load),
    .load_byte(shf_byte),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .byte_done(shf_done),
    .rx_byte  (shf_rx)
  );

  spi_irq_status #(
    .STS_W   (STS_W),
    .DONE_BIT(DONE_BIT)
  ) u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_done(seq_done),
    .clr     (int_clr),
    .en      (int_en),
    .sts     (int_sts),
    .irq     (irq)
  );

endmodule

// File: rtl/spi_burst_engine_checker.sv
module spi_burst_engine_checker #(
  parameter int STS_W    = 32,
  parameter int DONE_BIT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             cfg_discard_rx,
  input logic             busy,
  input logic             tx_valid,
  input logic             tx_pop,
  input logic             rx_push,
  input logic [STS_W-1:0] int_sts
);
  logic disc_q;

  always_ff @(posedge clk) begin
    if (rst) disc_q <= 1'b0;
    else if (start && !busy) disc_q <= cfg_discard_rx;
  end

  // R3: end of burst sets the completion flag
  a_r3_done_flag: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |=> int_sts[DONE_BIT]);

  // R9: a burst only begins from a start pulse
  a_r9_start_launches: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R12: never pop an empty transmit queue
  a_r12_pop_valid: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> tx_valid);

  // R8: discard mode suppresses pushes
  a_r8_no_push_discard: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !disc_q);

  // R1: queue traffic only during a burst
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tx_pop && !rx_push);

endmodule

bind spi_burst_engine spi_burst_engine_checker #(
  .STS_W   (STS_W),
  .DONE_BIT(DONE_BIT)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .cfg_discard_rx(cfg_discard_rx),
  .busy          (busy),
  .tx_valid      (tx_valid),
  .tx_pop        (tx_pop),
  .rx_push       (rx_push),
  .int_sts       (int_sts)
);

// File: tb/spi_burst_engine_bench.sv
module spi_burst_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 24;
  localparam int STS_W = 32;
  localparam int DONE_BIT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_tick;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_discard_rx = 0;
  logic [CNT_W-1:0] burst_len = '0, tx_len = '0;
  logic start = 1'b0;
  logic [STS_W-1:0] int_en = '0, int_clr = '0;
  logic [STS_W-1:0] int_sts;
  logic irq, busy, tx_valid, tx_pop, rx_push, sclk, mosi;
  logic miso = 1'b0;
  logic [7:0] tx_data, rx_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic tick_ph = 1'b0;
  always @(posedge clk) tick_ph <= ~tick_ph;
  assign sclk_tick = tick_ph;

  // transmit queue model
  logic [7:0] tx_mem [16];
  logic [4:0] tx_rd = '0, tx_n = '0;
  logic tx_hold = 1'b0;
  assign tx_valid = !tx_hold && (tx_rd < tx_n);
  assign tx_data  = tx_mem[tx_rd[3:0]];
  always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 5'd1;

  // receive queue model
  logic [7:0] rx_mem [16];
  int rx_n = 0;
  always @(posedge clk) if (rx_push) begin
    if (rx_n < 16) rx_mem[rx_n] <= rx_data;
    rx_n <= rx_n + 1;
  end

  spi_burst_engine #(.CNT_W(CNT_W), .STS_W(STS_W), .DONE_BIT(DONE_BIT)) u_spi_burst_engine (
    .clk(clk), .rst(rst), .sclk_tick(sclk_tick),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_discard_rx(cfg_discard_rx), .burst_len(burst_len), .tx_len(tx_len),
    .start(start), .int_en(int_en), .int_clr(int_clr), .int_sts(int_sts),
    .irq(irq), .busy(busy), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] sbyte(input int n);
    return 8'(8'h3C ^ (n * 37));
  endfunction

  function automatic int bpos(input int k, input logic lsb);
    return lsb ? k : 7 - k;
  endfunction

  // slave model
  logic active = 1'b0;
  logic s_cpol = 0, s_cpha = 0, s_lsb = 0;
  int edges = 0, s_edge = 0, s_byte = 0;
  logic [7:0] mosi_cap [16];
  always @(sclk) if (active) begin
    logic lead;
    logic [7:0] cur, nxt;
    int k;
    lead = (sclk != s_cpol);
    k = s_edge / 2;
    cur = sbyte(s_byte);
    nxt = sbyte(s_byte + 1);
    edges = edges + 1;
    if (lead != s_cpha) begin
      if (s_byte < 16) mosi_cap[s_byte][bpos(k, s_lsb)] = mosi;
    end else if (s_cpha) begin
      miso = cur[bpos(k, s_lsb)];
    end else if (k < 7) begin
      miso = cur[bpos(k + 1, s_lsb)];
    end else begin
      miso = nxt[bpos(0, s_lsb)];
    end
    s_edge = s_edge + 1;
    if (s_edge == 16) begin
      s_edge = 0;
      s_byte = s_byte + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reset_check();
    rst = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 mosi", 32'(mosi), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 status", int_sts, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 queues", 32'({tx_pop, rx_push}), 0);
  endtask

  // one full burst with slave checks; stall: empty queue at start; poke: restart mid-burst;
  // churn: change lengths and config mid-burst
  task automatic run_burst(input logic cpol, input logic cpha, input logic lsb,
                           input logic disc, input int blen, input int tlen,
                           input string tag, input bit stall, input bit poke,
                           input bit churn);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_discard_rx = disc;
    repeat (4) @(negedge clk);
    chk("R2 idle sclk", 32'(sclk), 32'(cpol));
    for (int i = 0; i < 16; i++) begin
      tx_mem[i] = 8'(8'h81 + i * 19 + blen);
      mosi_cap[i] = 8'h00;
    end
    tx_rd = '0; tx_n = 5'(tlen); rx_n = 0;
    edges = 0; s_edge = 0; s_byte = 0;
    s_cpol = cpol; s_cpha = cpha; s_lsb = lsb;
    begin
      logic [7:0] b0;
      b0 = sbyte(0);
      miso = cpha ? 1'b0 : b0[bpos(0, lsb)];
    end
    active = 1'b1;
    tx_hold = stall;
    burst_len = CNT_W'(blen); tx_len = CNT_W'(tlen);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (stall) begin
      repeat (20) @(negedge clk);
      chk("R12 no edge while starved", 32'(edges), 0);
      chk("R12 busy while starved", 32'(busy), 1);
      tx_hold = 1'b0;
    end
    if (poke || churn) begin
      repeat (12) @(negedge clk);
      if (poke) begin
        start = 1'b1;
        @(negedge clk) start = 1'b0;
      end
      if (churn) begin
        burst_len = CNT_W'(blen + 3); tx_len = '0;
        cfg_lsb_first = ~lsb; cfg_cpha = ~cpha; cfg_discard_rx = ~disc;
      end
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk({tag, " R3 edge count"}, 32'(edges), 32'(16 * blen));
    chk({tag, " R7 pops"}, 32'(tx_rd), 32'(tlen));
    chk({tag, " R8 push count"}, 32'(rx_n), disc ? 0 : 32'(blen));
    for (int n = 0; n < blen && n < 16; n++) begin
      if (n < tlen) chk({tag, " mosi byte"}, 32'(mosi_cap[n]), 32'(tx_mem[n]));
      else          chk({tag, " R7 filler byte"}, 32'(mosi_cap[n]), 0);
      if (!disc)    chk({tag, " received byte"}, 32'(rx_mem[n]), 32'(sbyte(n)));
    end
    chk({tag, " R3 done flag"}, 32'(int_sts[DONE_BIT]), 1);
    chk({tag, " R3 busy low"}, 32'(busy), 0);
    if (poke) begin
      repeat (10) @(negedge clk);
      chk("R9 no second burst", 32'(busy), 0);
      chk("R9 edges unchanged", 32'(edges), 32'(16 * blen));
    end
    active = 1'b0;
    cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_discard_rx = disc;
    int_clr = 32'(1) << DONE_BIT;
    @(negedge clk) int_clr = '0;
    @(negedge clk);
  endtask

  task automatic irq_check();
    cfg_cpol = 0; cfg_cpha = 0; cfg_discard_rx = 1;
    active = 1'b0; tx_n = '0; tx_rd = '0;
    burst_len = '0; tx_len = '0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 zero burst done", 32'(int_sts[DONE_BIT]), 1);
    chk("R10 masked irq", 32'(irq), 0);
    int_en = ~(32'(1) << DONE_BIT);
    repeat (2) @(negedge clk);
    chk("R10 other enables", 32'(irq), 0);
    int_en = 32'(1) << DONE_BIT;
    repeat (2) @(negedge clk);
    chk("R10 irq raised", 32'(irq), 1);
    int_clr = ~(32'(1) << DONE_BIT);
    @(negedge clk) int_clr = '0;
    repeat (2) @(negedge clk);
    chk("R10 zero bit keeps status", 32'(int_sts[DONE_BIT]), 1);
    int_clr = 32'(1) << DONE_BIT;
    @(negedge clk) int_clr = '0;
    chk("R10 status cleared", int_sts, 0);
    @(negedge clk);
    chk("R10 irq dropped", 32'(irq), 0);
    int_en = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    reset_check();
    run_burst(0, 0, 0, 0, 4, 4, "R4", 0, 0, 0);
    run_burst(0, 1, 0, 0, 3, 3, "R5", 0, 0, 0);
    run_burst(1, 0, 1, 0, 3, 3, "R6", 0, 0, 0);
    run_burst(1, 1, 1, 0, 2, 2, "R6", 0, 0, 0);
    run_burst(1, 1, 0, 0, 2, 2, "R2", 0, 0, 0);
    run_burst(0, 0, 0, 0, 5, 2, "R7", 0, 0, 0);
    run_burst(0, 1, 0, 1, 3, 3, "R8", 0, 0, 0);
    run_burst(0, 0, 1, 0, 2, 2, "R12", 1, 0, 0);
    run_burst(1, 0, 0, 0, 3, 3, "R9", 0, 1, 0);
    run_burst(0, 1, 1, 0, 3, 3, "R13", 0, 0, 1);
    run_burst(0, 0, 0, 0, 0, 0, "R11", 0, 0, 0);
    irq_check();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule